// File: doc/BRIEF.md
# I2C Bus Monitor and Slave Address Matcher

This block watches a two-wire bus without ever driving it. Both lines go through a short synchronizer chain and then through an edge detector that recognises START (data falling while the clock is high) and STOP (data rising while the clock is high). Every START opens an address phase. The block shifts in the first byte (most significant bit first) on rising clock edges and compares it with a programmable own address, either as a 7-bit address or as the two-byte 10-bit header sequence. It can also respond to the general-call address.

A recognised address produces a one-cycle match pulse and latches the read/write direction. A small set of sticky status flags records bus events. Each flag is cleared by a bus event rather than by a write: the stop, general-call and not-acknowledge flags clear on the next START, and the start flag clears on the next STOP. Two live indications report whether the bus is occupied and whether the clock line is currently held low during a transfer.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle pulse, and it is sampled whenever the consumer needs it. Nothing after the address bytes is decoded.

Top module: `i2c_addr_watch`

## Requirements
- R1: A START sets `bus_busy` and a STOP clears it. Both conditions are detected on the synchronized lines, and the reset state of the lines is high.
- R2: In 7-bit mode (`addr10_mode`=0), bits 7:1 of the first byte after a START are compared with `own_addr[6:0]`, and `own_addr[9:7]` is ignored. Bit 0 of that byte is the direction (1 = read).
- R3: In 10-bit mode (`addr10_mode`=1), a match requires a first byte of the form 1,1,1,1,0,`own_addr[9]`,`own_addr[8]`,rw and then a second byte equal to `own_addr[7:0]`. The direction is bit 0 of the first byte.
- R4: A first byte of 0x00 (general call) matches in either mode only when `gc_enable`=1, and it then sets `flag_gc`. A first byte with bits 7:1 all zero never matches the own address, so 0x01 never matches.
- R5: Each match produces exactly one single-cycle `match_pulse`. `rw_dir` then holds the direction bit of the matched transfer until the next match.
- R6: `flag_start` is set by a match and cleared only by a STOP. It therefore survives a repeated START.
- R7: `flag_stop` is set by a STOP. `flag_stop`, `flag_gc` and `flag_nack` are all cleared by a START.
- R8: `flag_nack` is set when SDA is high at the ninth rising clock edge after a START, which is the acknowledge slot of the first byte. The acknowledge slot of a second byte has no effect on it.
- R9: `scl_held_low` is 1 while the bus is busy and the synchronized clock line is low, and 0 otherwise.
- R10: While reset is asserted, all flags, `bus_busy`, `scl_held_low`, `match_pulse` and `rw_dir` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| own_addr | input | 10 | Own address, right-justified |
| addr10_mode | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 lets the general-call address match |
| match_pulse | output | 1 | One-cycle pulse on an address match |
| rw_dir | output | 1 | Direction of the last match (1 = read) |
| flag_start | output | 1 | Addressed since the last STOP |
| flag_stop | output | 1 | STOP seen since the last START |
| flag_nack | output | 1 | First-byte acknowledge slot was high |
| flag_gc | output | 1 | General call matched since the last START |
| bus_busy | output | 1 | Bus between a START and a STOP |
| scl_held_low | output | 1 | Clock line low during a transfer |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except at START and STOP. Each line level is also held for longer than the synchronizer delay, so that a START and a STOP never fall in the same cycle and every SCL rise is seen once. The stimulus moves the lines in quarter-bit steps of three clocks and changes SDA only in the low phase of the clock. The sweeps cover every 7-bit first byte with the general-call enable both off and on. They also cover every 10-bit header byte against correct and single-bit-corrupted second bytes, and a repeated START after a general call.

// File: rtl/i2caw_pkg.sv
package i2caw_pkg;
  localparam int OWN_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int ADDR7_W = 7;
  localparam int HDR_W   = 5;
  localparam int HI_W    = OWN_W - BYTE_W;
  localparam logic [HDR_W-1:0] HDR10 = 5'b11110;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FIRST,
    PH_SECOND
  } phase_t;
endpackage

// File: rtl/i2caw_sync.sv
module i2caw_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= INIT;
        else        chain[g] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= INIT;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2caw_cond.sv
module i2caw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // clock steady high across both samples marks a bus condition
  assign start_ev = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_ev  = scl_p & scl_s & ~sda_p & sda_s;
  assign scl_rise = ~scl_p & scl_s;
endmodule

// File: rtl/i2caw_shifter.sv
module i2caw_shifter
  import i2caw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic              go_second,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              in_second,
  output logic              first_nack
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              active;

  assign active = (phase != PH_IDLE) && scl_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
    end else if (start_ev) begin
      phase  <= PH_FIRST;
      bitcnt <= '0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
    end else if (active) begin
      if (bitcnt != ACK_BIT) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end else begin
        bitcnt <= '0;
        phase  <= (phase == PH_FIRST && go_second) ? PH_SECOND : PH_IDLE;
      end
    end
  end

  // the byte is complete on its last data edge, with the live bit appended
  assign byte_done  = active && (bitcnt == LAST_BIT);
  assign byte_val   = {shreg[BYTE_W-2:0], sda_s};
  assign in_second  = (phase == PH_SECOND);
  assign first_nack = active && (bitcnt == ACK_BIT) && (phase == PH_FIRST) && sda_s;
endmodule

// File: rtl/i2caw_matcher.sv
module i2caw_matcher
  import i2caw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              byte_done,
  input  logic              in_second,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic              addr10_mode,
  input  logic              gc_enable,
  output logic              hit,
  output logic              hit_gc,
  output logic              hit_rw,
  output logic              hdr_pend
);
  logic [ADDR7_W-1:0] addr7;
  logic               rw_bit, is_zero, hdr_ok;
  logic               first_hit, second_hit, gc_now, hit_now;
  logic               rw_hold;

  assign addr7   = byte_val[BYTE_W-1:1];
  assign rw_bit  = byte_val[0];
  assign is_zero = (addr7 == '0);
  assign hdr_ok  = (byte_val[BYTE_W-1 -: HDR_W] == HDR10) &&
                   (byte_val[HI_W:1] == own_addr[OWN_W-1 -: HI_W]);

  assign gc_now     = is_zero & gc_enable & ~rw_bit;
  assign first_hit  = is_zero ? gc_now
                              : (~addr10_mode & (addr7 == own_addr[ADDR7_W-1:0]));
  assign second_hit = hdr_pend & (byte_val == own_addr[BYTE_W-1:0]);
  assign hit_now    = byte_done & (in_second ? second_hit : first_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_gc   <= 1'b0;
      hit_rw   <= 1'b0;
      hdr_pend <= 1'b0;
      rw_hold  <= 1'b0;
    end else begin
      hit    <= hit_now;
      hit_gc <= byte_done & ~in_second & gc_now;
      if (hit_now) hit_rw <= in_second ? rw_hold : rw_bit;
      if (start_ev) begin
        hdr_pend <= 1'b0;
      end else if (byte_done && !in_second) begin
        hdr_pend <= addr10_mode & ~is_zero & hdr_ok;
        rw_hold  <= rw_bit;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
  import i2caw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [OWN_W-1:0] own_addr,
  input  logic             addr10_mode,
  input  logic             gc_enable,
  output logic             match_pulse,
  output logic             rw_dir,
  output logic             flag_start,
  output logic             flag_stop,
  output logic             flag_nack,
  output logic             flag_gc,
  output logic             bus_busy,
  output logic             scl_held_low
);
  logic              scl_s, sda_s;
  logic              start_ev, stop_ev, scl_rise;
  logic              byte_done, in_second, first_nack;
  logic [BYTE_W-1:0] byte_val;
  logic              hit, hit_gc, hit_rw, hdr_pend;

  i2caw_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  i2caw_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  i2caw_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise));

  i2caw_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .sda_s(sda_s), .go_second(hdr_pend),
    .byte_done(byte_done), .byte_val(byte_val), .in_second(in_second),
    .first_nack(first_nack));

  i2caw_matcher u_match (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .byte_done(byte_done),
    .in_second(in_second), .byte_val(byte_val), .own_addr(own_addr),
    .addr10_mode(addr10_mode), .gc_enable(gc_enable),
    .hit(hit), .hit_gc(hit_gc), .hit_rw(hit_rw), .hdr_pend(hdr_pend));

  // event flags: each is set by one bus event and cleared by another
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_start   <= 1'b0;
      flag_stop    <= 1'b0;
      flag_nack    <= 1'b0;
      flag_gc      <= 1'b0;
      bus_busy     <= 1'b0;
      scl_held_low <= 1'b0;
    end else begin
      if (hit)           flag_start <= 1'b1;
      else if (stop_ev)  flag_start <= 1'b0;

      if (stop_ev)       flag_stop <= 1'b1;
      else if (start_ev) flag_stop <= 1'b0;

      if (start_ev)        flag_nack <= 1'b0;
      else if (first_nack) flag_nack <= 1'b1;

      if (start_ev)    flag_gc <= 1'b0;
      else if (hit_gc) flag_gc <= 1'b1;

      if (start_ev)     bus_busy <= 1'b1;
      else if (stop_ev) bus_busy <= 1'b0;

      scl_held_low <= bus_busy & ~scl_s;
    end
  end

  assign match_pulse = hit;
  assign rw_dir      = hit_rw;
endmodule

// File: rtl/i2caw_checker.sv
module i2caw_checker (
  input logic clk,
  input logic rst_n,
  input logic start_ev,
  input logic stop_ev,
  input logic match_pulse,
  input logic flag_start,
  input logic flag_stop,
  input logic flag_nack,
  input logic flag_gc,
  input logic bus_busy,
  input logic scl_held_low
);
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> bus_busy);
  p_busy_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !bus_busy);
  p_gc_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_gc) |-> $past(match_pulse));
  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);
  p_start_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> flag_start);
  p_start_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_start) |-> $past(match_pulse));
  p_start_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !flag_start);
  p_stop_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> flag_stop);
  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!flag_stop && !flag_gc && !flag_nack));
  p_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_held_low |-> bus_busy);
endmodule

bind i2c_addr_watch i2caw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
  .match_pulse(match_pulse), .flag_start(flag_start), .flag_stop(flag_stop),
  .flag_nack(flag_nack), .flag_gc(flag_gc), .bus_busy(bus_busy),
  .scl_held_low(scl_held_low));

// File: tb/sim_i2c_addr_watch.sv
`timescale 1ns/1ps
module sim_i2c_addr_watch;
  localparam int Q = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_r = 1'b1, sda_r = 1'b1;
  logic [9:0] own_addr = '0;
  logic addr10_mode = 1'b0, gc_enable = 1'b0;
  logic match_pulse, rw_dir, flag_start, flag_stop, flag_nack, flag_gc;
  logic bus_busy, scl_held_low;

  int nchk = 0, nerr = 0, mcount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_addr_watch u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_r), .sda_in(sda_r),
    .own_addr(own_addr), .addr10_mode(addr10_mode), .gc_enable(gc_enable),
    .match_pulse(match_pulse), .rw_dir(rw_dir), .flag_start(flag_start),
    .flag_stop(flag_stop), .flag_nack(flag_nack), .flag_gc(flag_gc),
    .bus_busy(bus_busy), .scl_held_low(scl_held_low));

  always @(negedge clk) if (match_pulse) mcount++;

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    nchk++;
    if (act != exp_v) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    sda_r = v; wq(); scl_r = 1'b1; wq(); wq(); scl_r = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic a);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    send_bit(a);
  endtask

  task automatic do_start();
    sda_r = 1'b1; wq(); scl_r = 1'b1; wq(); sda_r = 1'b0; wq(); wq(); scl_r = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_r = 1'b0; wq(); scl_r = 1'b1; wq(); sda_r = 1'b1; wq(); wq();
  endtask

  // one transfer: START, address byte(s), STOP, with checks around it
  task automatic txn(input string req, input logic [7:0] b0, input bit has2,
                     input logic [7:0] b1, input logic ack,
                     input int exp_m, input int exp_rw, input int exp_gc);
    int m0;
    m0 = mcount;
    do_start();
    chk("R1", "busy after START", bus_busy, 1);
    chk("R7", "stop flag after START", flag_stop, 0);
    send_byte(b0, ack);
    wq();
    chk("R8", "nack after first byte", flag_nack, ack);
    if (has2) begin
      send_byte(b1, 1'b1);
      wq();
      chk("R8", "nack after second byte", flag_nack, ack);
    end
    chk(req, "match count", mcount - m0, exp_m);
    chk("R6", "start flag", flag_start, exp_m);
    chk("R4", "gc flag", flag_gc, exp_gc);
    if (exp_m != 0) chk("R5", "rw_dir", rw_dir, exp_rw);
    chk("R9", "scl held low", scl_held_low, 1);
    do_stop();
    chk("R1", "busy after STOP", bus_busy, 0);
    chk("R7", "stop flag after STOP", flag_stop, 1);
    chk("R6", "start flag after STOP", flag_start, 0);
    chk("R9", "scl low after STOP", scl_held_low, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", bus_busy, 0);
    chk("R10", "flags", {flag_start, flag_stop, flag_nack, flag_gc}, 0);
    chk("R10", "match/rw/low", {match_pulse, rw_dir, scl_held_low}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 and R4 sweep: every first byte, general call off then on
    addr10_mode = 1'b0;
    own_addr = 10'h35A;
    for (int i = 0; i < 512; i++) begin
      logic [7:0] b;
      logic g, a;
      int em, eg;
      b = i[7:0];
      g = i[8];
      a = b[2] ^ b[5] ^ g;
      gc_enable = g;
      if (b[7:1] == 7'd0) begin
        em = (g && !b[0]) ? 1 : 0;
        eg = em;
      end else begin
        em = (b[7:1] == own_addr[6:0]) ? 1 : 0;
        eg = 0;
      end
      txn("R2", b, 1'b0, 8'h00, a, em, b[0], eg);
    end

    // R3 sweep: every 10-bit header byte against good and corrupted low bytes
    addr10_mode = 1'b1;
    gc_enable = 1'b1;
    own_addr = 10'h2C7;
    for (int h = 0; h < 8; h++) begin
      for (int k = 0; k < 10; k++) begin
        logic [7:0] b0, b1;
        int em;
        b0 = 8'hF0 + h[7:0];
        if (k < 8)       b1 = own_addr[7:0] ^ (8'h01 << k);
        else if (k == 8) b1 = own_addr[7:0];
        else             b1 = 8'h00;
        em = (b0[2:1] == own_addr[9:8] && b1 == own_addr[7:0]) ? 1 : 0;
        txn("R3", b0, 1'b1, b1, h[0] ^ k[0], em, b0[0], 0);
      end
    end
    // R3: a 7-bit pattern equal to own low bits must not match in 10-bit mode
    txn("R3", {own_addr[6:0], 1'b0}, 1'b0, 8'h00, 1'b0, 0, 0, 0);
    // R4: general call in 10-bit mode
    txn("R4", 8'h00, 1'b0, 8'h00, 1'b0, 1, 0, 1);
    gc_enable = 1'b0;
    txn("R4", 8'h00, 1'b0, 8'h00, 1'b0, 0, 0, 0);

    // R6/R7: repeated START keeps start flag, clears gc and nack
    addr10_mode = 1'b0;
    gc_enable = 1'b1;
    do_start();
    send_byte(8'h00, 1'b1);
    wq();
    chk("R4", "gc before repeat", flag_gc, 1);
    chk("R8", "nack before repeat", flag_nack, 1);
    do_start();
    chk("R6", "start flag across repeated START", flag_start, 1);
    chk("R7", "gc cleared by START", flag_gc, 0);
    chk("R7", "nack cleared by START", flag_nack, 0);
    send_byte(8'h12, 1'b0);
    wq();
    chk("R6", "start flag still set", flag_start, 1);
    do_stop();
    chk("R6", "start flag cleared by STOP", flag_start, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule